// File: doc/BRIEF.md
# PCM Voice Slot Serial Transceiver

This block moves linear voice samples between parallel sample ports and a serial PCM data line. The serial line is divided into 16-bit time slots. An external clock and sync source supplies the timing. It gives one-cycle strobes for the rising and falling edges of the bit clock, together with the slot number and the bit number within that slot. The transceiver only reacts to these strobes, so it never generates bit-clock or frame timing itself.

A sample is 8 or 13 bits wide and is placed into a 16-bit slot word. Two fill modes are available:
- **Padding:** the sample is left-aligned and followed by filler. For 13-bit samples the filler is a 3-bit gain code; for 8-bit samples it is zeros.
- **Sign extension:** the sample is right-aligned and its sign bit is repeated above it.

One configuration bit sets the bit order, MSB first or LSB first, and it applies to both directions. A slot mask chooses which slots carry traffic. The transmit side can be muted. It can also release the data line between active slots, either right after the falling bit-clock edge of the last bit or at the next rising edge. The receive side strips the fill, presents the sample and pulses a one-cycle valid strobe at the end of every active slot.

Top module: `pcm_slot_xcvr`

## Requirements
- R1: In padding mode with 13-bit samples, the slot word is sample[12:0] in word bits [15:3] and cfg_gain[2:0] in word bits [2:0].
- R2: In padding mode with 8-bit samples, the slot word is sample[7:0] in word bits [15:8] and zeros in word bits [7:0].
- R3: In sign-extension mode, a 13-bit sample fills word bits [12:0] and bits [15:13] copy sample[12]. An 8-bit sample fills word bits [7:0] and bits [15:8] copy sample[7].
- R4: Bit order applies to both directions. With cfg_lsb_first=0, bit index b carries word bit 15-b. With cfg_lsb_first=1, bit index b carries word bit b.
- R5: pcm_out changes only on the clock edge where bclk_rise is high, and holds through the falling strobe. pcm_in is sampled on the clock edge where bclk_fall is high.
- R6: A slot whose bit in slot_mask (bit n for slot n) is 0 is inactive. It produces no rx_valid, and pcm_out is 0 during it.
- R7: At the falling strobe of bit 15 of an active slot, the slot word is completed. In the next cycle, rx_sample holds the recovered sample with the fill removed and zero-extended to 13 bits, and rx_valid is high for exactly one cycle.
- R8: With cfg_hiz_en=1 and cfg_hiz_on_rise=0, pcm_oe drops at the falling strobe of bit 15 of an active slot when the next slot is inactive. If the next slot is active, pcm_oe stays high.
- R9: With cfg_hiz_en=1 and cfg_hiz_on_rise=1, pcm_oe stays high through that falling strobe. It drops at the following rising strobe of an inactive slot.
- R10: With cfg_hiz_en=0, pcm_oe is 1 at all times.
- R11: cfg_mute=1 makes pcm_out 0 for active slots. The output enable and receive timing are unchanged.
- R12: The transmit word is captured at the rising strobe of bit 0 of an active slot, from the last sample loaded with tx_load. Without a new load, the same sample is sent again.
- R13: After reset, pcm_out=0 and rx_valid=0, and pcm_oe=0 when cfg_hiz_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_rise | input | 1 | One-cycle strobe for a rising bit-clock edge |
| bclk_fall | input | 1 | One-cycle strobe for a falling bit-clock edge |
| slot_idx | input | 2 | Slot number, valid with bclk_rise |
| bit_idx | input | 4 | Bit number within the slot, valid with bclk_rise |
| slot_mask | input | 4 | Active-slot mask, bit n for slot n |
| cfg_sign_fill | input | 1 | 0 = padding fill, 1 = sign extension |
| cfg_len13 | input | 1 | 0 = 8-bit samples, 1 = 13-bit samples |
| cfg_lsb_first | input | 1 | 0 = MSB first, 1 = LSB first |
| cfg_hiz_en | input | 1 | Release the data line between active slots |
| cfg_hiz_on_rise | input | 1 | Release at the next rising edge instead of the falling edge |
| cfg_mute | input | 1 | Force transmitted data to 0 |
| cfg_gain | input | 3 | Gain code used as filler for padded 13-bit samples |
| tx_sample | input | 13 | Transmit sample (8-bit samples use bits [7:0]) |
| tx_load | input | 1 | Strobe that loads tx_sample |
| pcm_in | input | 1 | Serial receive data |
| pcm_out | output | 1 | Serial transmit data |
| pcm_oe | output | 1 | Output enable for pcm_out |
| rx_sample | output | 13 | Recovered receive sample |
| rx_valid | output | 1 | One-cycle strobe when rx_sample is updated |

## Verification
The embedded assertions assume the following about the strobes:
- bclk_rise and bclk_fall are single-cycle pulses.
- They never coincide, and they alternate with at least one idle cycle between them.
- slot_idx and bit_idx are valid when bclk_rise is high.
- tx_load never arrives in the same cycle as the rising strobe that starts a slot.

Under these assumptions the receive strobe cannot repeat in back-to-back cycles, and every change of the output or of its enable can be traced to a strobe. The bench keeps within this envelope:
- It spaces each strobe by one idle cycle and walks the indices through whole frames in order.
- It loads transmit samples only between frames.
- It toggles pcm_in right after each falling strobe, so a receiver that sampled at the wrong time would be caught.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    localparam int SLOT_W   = 16;
    localparam int BIT_W    = 4;
    localparam int SAMPLE_W = 13;
    localparam int NARROW_W = 8;
    localparam int GAIN_W   = 3;

    typedef enum logic {
        FILL_PAD  = 1'b0,
        FILL_SIGN = 1'b1
    } fill_e;

    typedef enum logic {
        LEN_8  = 1'b0,
        LEN_13 = 1'b1
    } len_e;

    typedef struct packed {
        fill_e             fill;
        len_e              len;
        logic              lsb_first;
        logic              hiz_en;
        logic              hiz_on_rise;
        logic              mute;
        logic [GAIN_W-1:0] gain;
    } slot_cfg_t;

    // Map a bit index within the slot to a position in the slot word.
    function automatic logic [BIT_W-1:0] wire_pos(input logic [BIT_W-1:0] b,
                                                  input logic lsb_first);
        return lsb_first ? b : (BIT_W'(SLOT_W - 1) - b);
    endfunction

    // Place a sample into a 16-bit slot word according to the fill mode.
    function automatic logic [SLOT_W-1:0] pack_slot(input logic [SAMPLE_W-1:0] s,
                                                    input slot_cfg_t c);
        logic [SLOT_W-1:0] w;
        unique case ({c.fill, c.len})
            {FILL_PAD,  LEN_13}: w = {s, c.gain};
            {FILL_PAD,  LEN_8 }: w = {s[NARROW_W-1:0], {(SLOT_W-NARROW_W){1'b0}}};
            {FILL_SIGN, LEN_13}: w = {{(SLOT_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
            default:             w = {{(SLOT_W-NARROW_W){s[NARROW_W-1]}}, s[NARROW_W-1:0]};
        endcase
        return w;
    endfunction

    // Strip the fill from a received slot word.
    function automatic logic [SAMPLE_W-1:0] unpack_slot(input logic [SLOT_W-1:0] w,
                                                        input slot_cfg_t c);
        logic [SAMPLE_W-1:0] s;
        unique case ({c.fill, c.len})
            {FILL_PAD,  LEN_13}: s = w[SLOT_W-1:SLOT_W-SAMPLE_W];
            {FILL_PAD,  LEN_8 }: s = {{(SAMPLE_W-NARROW_W){1'b0}}, w[SLOT_W-1:SLOT_W-NARROW_W]};
            {FILL_SIGN, LEN_13}: s = w[SAMPLE_W-1:0];
            default:             s = {{(SAMPLE_W-NARROW_W){1'b0}}, w[NARROW_W-1:0]};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcm_slot_tracker.sv
module pcm_slot_tracker
    import pcm_slot_pkg::*;
#(
    parameter int N_SLOTS = 4,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bclk_rise,
    input  logic [IDX_W-1:0]   slot_idx,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic [N_SLOTS-1:0] slot_mask,
    output logic               rise_act,
    output logic [BIT_W-1:0]   cur_bit,
    output logic               cur_act,
    output logic               cur_last,
    output logic               next_act
);

    logic [IDX_W-1:0] cur_slot_q;
    logic [IDX_W-1:0] next_slot;

    assign rise_act = slot_mask[slot_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_slot_q <= '0;
            cur_bit    <= '0;
            cur_act    <= 1'b0;
        end else if (bclk_rise) begin
            cur_slot_q <= slot_idx;
            cur_bit    <= bit_idx;
            cur_act    <= rise_act;
        end
    end

    assign next_slot = (cur_slot_q == IDX_W'(N_SLOTS - 1)) ? '0 : cur_slot_q + 1'b1;
    assign next_act  = slot_mask[next_slot];
    assign cur_last  = (cur_bit == BIT_W'(SLOT_W - 1));

    // The latched activity flag only moves on a rising strobe.
    AST_ACT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_act) |-> $past(bclk_rise)) else $error("cur_act moved"); // R6

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_slot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  slot_cfg_t           cfg,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic [BIT_W-1:0]    bit_idx,
    input  logic                rise_act,
    input  logic                cur_act,
    input  logic                cur_last,
    input  logic                next_act,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                tx_load,
    output logic                pcm_out,
    output logic                pcm_oe
);

    logic [SAMPLE_W-1:0] hold_q;
    logic [SLOT_W-1:0]   word_q;
    logic [SLOT_W-1:0]   launch_word;
    logic [SLOT_W-1:0]   live_word;
    logic                slot_start;
    logic                tx_bit;
    logic                out_q;
    logic                oe_q;
    logic                release_fall;

    assign launch_word  = pack_slot(hold_q, cfg);
    assign slot_start   = (bit_idx == '0);
    assign live_word    = slot_start ? launch_word : word_q;
    assign tx_bit       = live_word[wire_pos(bit_idx, cfg.lsb_first)];
    assign release_fall = bclk_fall && cur_act && cur_last && !next_act && !cfg.hiz_on_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            word_q <= '0;
            out_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (tx_load) hold_q <= tx_sample;
            if (bclk_rise) begin
                if (rise_act) begin
                    if (slot_start) word_q <= launch_word;
                    out_q <= cfg.mute ? 1'b0 : tx_bit;
                    oe_q  <= 1'b1;
                end else begin
                    out_q <= 1'b0;
                    oe_q  <= 1'b0;
                end
            end else if (release_fall) begin
                oe_q <= 1'b0;
            end
        end
    end

    assign pcm_out = out_q;
    assign pcm_oe  = cfg.hiz_en ? oe_q : 1'b1;

    AST_OUT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q) |-> $past(bclk_rise)) else $error("out moved off rise"); // R5
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bclk_rise && cfg.mute |=> !out_q) else $error("muted bit not zero"); // R11
    AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        bclk_rise && !rise_act |=> !out_q && !oe_q) else $error("idle slot driven"); // R6
    AST_OE_DROP_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_q) |-> $past(bclk_fall || bclk_rise)) else $error("oe dropped off strobe"); // R8
    AST_RISE_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        bclk_fall && cfg.hiz_on_rise |=> $stable(oe_q)) else $error("oe moved at fall"); // R9

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_slot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  slot_cfg_t           cfg,
    input  logic                bclk_fall,
    input  logic [BIT_W-1:0]    cur_bit,
    input  logic                cur_act,
    input  logic                cur_last,
    input  logic                pcm_in,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);

    logic [SLOT_W-1:0]   word_q;
    logic [SLOT_W-1:0]   word_nxt;
    logic [SAMPLE_W-1:0] sample_q;
    logic                valid_q;
    logic                capture;

    assign capture = bclk_fall && cur_act;

    always_comb begin
        word_nxt = word_q;
        word_nxt[wire_pos(cur_bit, cfg.lsb_first)] = pcm_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (capture) begin
                word_q <= word_nxt;
                if (cur_last) begin
                    sample_q <= unpack_slot(word_nxt, cfg);
                    valid_q  <= 1'b1;
                end
            end
        end
    end

    assign rx_sample = sample_q;
    assign rx_valid  = valid_q;

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid) else $error("rx_valid too long"); // R7
    AST_RX_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bclk_fall)) else $error("rx_valid without fall"); // R7
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_sample)) else $error("rx_sample moved silently"); // R7

endmodule

// File: rtl/pcm_slot_xcvr.sv
module pcm_slot_xcvr
    import pcm_slot_pkg::*;
#(
    parameter int N_SLOTS = 4,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic [IDX_W-1:0]    slot_idx,
    input  logic [BIT_W-1:0]    bit_idx,
    input  logic [N_SLOTS-1:0]  slot_mask,
    input  logic                cfg_sign_fill,
    input  logic                cfg_len13,
    input  logic                cfg_lsb_first,
    input  logic                cfg_hiz_en,
    input  logic                cfg_hiz_on_rise,
    input  logic                cfg_mute,
    input  logic [GAIN_W-1:0]   cfg_gain,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                tx_load,
    input  logic                pcm_in,
    output logic                pcm_out,
    output logic                pcm_oe,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);

    slot_cfg_t        cfg;
    logic             rise_act;
    logic [BIT_W-1:0] cur_bit;
    logic             cur_act;
    logic             cur_last;
    logic             next_act;

    always_comb begin
        cfg.fill        = cfg_sign_fill ? FILL_SIGN : FILL_PAD;
        cfg.len         = cfg_len13 ? LEN_13 : LEN_8;
        cfg.lsb_first   = cfg_lsb_first;
        cfg.hiz_en      = cfg_hiz_en;
        cfg.hiz_on_rise = cfg_hiz_on_rise;
        cfg.mute        = cfg_mute;
        cfg.gain        = cfg_gain;
    end

    pcm_slot_tracker #(.N_SLOTS(N_SLOTS)) u_track (
        .clk       (clk),
        .rst       (rst),
        .bclk_rise (bclk_rise),
        .slot_idx  (slot_idx),
        .bit_idx   (bit_idx),
        .slot_mask (slot_mask),
        .rise_act  (rise_act),
        .cur_bit   (cur_bit),
        .cur_act   (cur_act),
        .cur_last  (cur_last),
        .next_act  (next_act)
    );

    pcm_tx_lane u_tx (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .bit_idx   (bit_idx),
        .rise_act  (rise_act),
        .cur_act   (cur_act),
        .cur_last  (cur_last),
        .next_act  (next_act),
        .tx_sample (tx_sample),
        .tx_load   (tx_load),
        .pcm_out   (pcm_out),
        .pcm_oe    (pcm_oe)
    );

    pcm_rx_lane u_rx (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .bclk_fall (bclk_fall),
        .cur_bit   (cur_bit),
        .cur_act   (cur_act),
        .cur_last  (cur_last),
        .pcm_in    (pcm_in),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid)
    );

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        !(bclk_rise && bclk_fall)) else $error("strobes coincide"); // R5
    AST_OE_FIXED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_hiz_en && $past(!cfg_hiz_en) |-> pcm_oe && $past(pcm_oe)) else $error("oe low"); // R10

endmodule

// File: tb/tb_pcm_slot_xcvr.sv
module tb_pcm_slot_xcvr;

    logic        clk = 1'b0;
    logic        rst;
    logic        bclk_rise, bclk_fall;
    logic [1:0]  slot_idx;
    logic [3:0]  bit_idx;
    logic [3:0]  slot_mask;
    logic        cfg_sign_fill, cfg_len13, cfg_lsb_first;
    logic        cfg_hiz_en, cfg_hiz_on_rise, cfg_mute;
    logic [2:0]  cfg_gain;
    logic [12:0] tx_sample;
    logic        tx_load;
    logic        pcm_in;
    logic        pcm_out, pcm_oe;
    logic [12:0] rx_sample;
    logic        rx_valid;

    int checks = 0;
    int errors = 0;

    logic [15:0] rx_feed  [4];
    logic [15:0] tx_seen  [4];
    logic        oe_mid   [4][16];
    logic        oe_fall  [4][16];
    logic [12:0] rx_log   [8];
    int          rx_n;
    int          out_moved;

    always #2 clk = ~clk;

    pcm_slot_xcvr dut (
        .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .slot_mask(slot_mask),
        .cfg_sign_fill(cfg_sign_fill), .cfg_len13(cfg_len13),
        .cfg_lsb_first(cfg_lsb_first), .cfg_hiz_en(cfg_hiz_en),
        .cfg_hiz_on_rise(cfg_hiz_on_rise), .cfg_mute(cfg_mute),
        .cfg_gain(cfg_gain), .tx_sample(tx_sample), .tx_load(tx_load),
        .pcm_in(pcm_in), .pcm_out(pcm_out), .pcm_oe(pcm_oe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid && rx_n < 8) begin
            rx_log[rx_n] = rx_sample;
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [12:0] s, input bit len13,
                                             input bit sgn, input logic [2:0] g);
        logic [15:0] w;
        if (!sgn && len13)      w = {s, g};
        else if (!sgn)          w = {s[7:0], 8'h00};
        else if (len13)         w = {{3{s[12]}}, s};
        else                    w = {{8{s[7]}}, s[7:0]};
        return w;
    endfunction

    function automatic logic [12:0] exp_rx(input logic [15:0] w, input bit len13, input bit sgn);
        if (!sgn && len13) return w[15:3];
        if (!sgn)          return {5'd0, w[15:8]};
        if (len13)         return w[12:0];
        return {5'd0, w[7:0]};
    endfunction

    function automatic int pos(input int b);
        return cfg_lsb_first ? b : 15 - b;
    endfunction

    task automatic bit_step(input int s, input int b);
        logic mid;
        @(negedge clk);
        slot_idx  = 2'(s);
        bit_idx   = 4'(b);
        bclk_rise = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0;
        mid = pcm_out;
        tx_seen[s][pos(b)] = pcm_out;
        oe_mid[s][b] = pcm_oe;
        pcm_in = rx_feed[s][pos(b)];
        @(negedge clk);
        bclk_fall = 1'b1;
        @(negedge clk);
        bclk_fall = 1'b0;
        oe_fall[s][b] = pcm_oe;
        if (pcm_out != mid) out_moved++;
        pcm_in = ~pcm_in;
        @(negedge clk);
    endtask

    task automatic run_frame();
        rx_n = 0;
        out_moved = 0;
        for (int s = 0; s < 4; s++)
            for (int b = 0; b < 16; b++)
                bit_step(s, b);
        repeat (3) @(negedge clk);
    endtask

    task automatic load(input logic [12:0] v);
        @(negedge clk);
        tx_sample = v;
        tx_load   = 1'b1;
        @(negedge clk);
        tx_load   = 1'b0;
    endtask

    task automatic t_reset();
        cfg_hiz_en = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13", "pcm_out after reset", int'(pcm_out), 0);
        chk("R13", "rx_valid after reset", int'(rx_valid), 0);
        chk("R13", "pcm_oe after reset", int'(pcm_oe), 0);
    endtask

    task automatic t_pad13_msb();
        logic [15:0] w;
        cfg_sign_fill = 0; cfg_len13 = 1; cfg_lsb_first = 0;
        cfg_hiz_en = 1; cfg_hiz_on_rise = 0; cfg_mute = 0; cfg_gain = 3'd5;
        slot_mask = 4'b0101;
        rx_feed[0] = 16'hBEEF; rx_feed[1] = 16'hFFFF;
        rx_feed[2] = 16'h1234; rx_feed[3] = 16'hFFFF;
        load(13'h1A5C);
        run_frame();
        w = exp_word(13'h1A5C, 1, 0, 3'd5);
        chk("R1", "pad13 slot0 word", int'(tx_seen[0]), int'(w));
        chk("R4", "msb-first slot2 word", int'(tx_seen[2]), int'(w));
        chk("R6", "idle slot1 data", int'(tx_seen[1]), 0);
        chk("R6", "idle slot1 oe", int'(oe_mid[1][5]), 0);
        chk("R6", "rx strobes for two active slots", rx_n, 2);
        chk("R7", "rx slot0 sample", int'(rx_log[0]), int'(exp_rx(16'hBEEF, 1, 0)));
        chk("R7", "rx slot2 sample", int'(rx_log[1]), int'(exp_rx(16'h1234, 1, 0)));
        chk("R8", "oe mid last bit", int'(oe_mid[0][15]), 1);
        chk("R8", "oe after last fall", int'(oe_fall[0][15]), 0);
        chk("R5", "pcm_out moved at fall", out_moved, 0);
    endtask

    task automatic t_pad8_lsb();
        cfg_sign_fill = 0; cfg_len13 = 0; cfg_lsb_first = 1;
        slot_mask = 4'b0010;
        rx_feed[1] = 16'hA55A;
        load(13'h00C3);
        run_frame();
        chk("R2", "pad8 word", int'(tx_seen[1]), int'(exp_word(13'h00C3, 0, 0, 3'd5)));
        chk("R4", "lsb-first rx", rx_n == 1 ? int'(rx_log[0]) : -1, int'(exp_rx(16'hA55A, 0, 0)));
    endtask

    task automatic t_sign();
        int lows;
        cfg_sign_fill = 1; cfg_len13 = 1; cfg_lsb_first = 0;
        cfg_hiz_en = 0; slot_mask = 4'b1111;
        for (int s = 0; s < 4; s++) rx_feed[s] = 16'hE123;
        load(13'h1F00);
        run_frame();
        chk("R3", "sign13 word", int'(tx_seen[3]), int'(exp_word(13'h1F00, 1, 1, 3'd5)));
        chk("R7", "sign13 rx", int'(rx_log[3]), int'(exp_rx(16'hE123, 1, 1)));
        lows = 0;
        for (int s = 0; s < 4; s++)
            for (int b = 0; b < 16; b++)
                if (!oe_mid[s][b] || !oe_fall[s][b]) lows++;
        chk("R10", "oe low samples with release off", lows, 0);
        cfg_len13 = 0;
        rx_feed[0] = 16'hFF80;
        load(13'h007F);
        run_frame();
        chk("R3", "sign8 word", int'(tx_seen[0]), int'(exp_word(13'h007F, 0, 1, 3'd5)));
        chk("R3", "sign8 rx", int'(rx_log[0]), int'(exp_rx(16'hFF80, 0, 1)));
        load(13'h0085);
        run_frame();
        chk("R3", "sign8 negative word", int'(tx_seen[2]), 16'hFF85);
    endtask

    task automatic t_release();
        cfg_sign_fill = 0; cfg_len13 = 1; cfg_hiz_en = 1;
        cfg_hiz_on_rise = 1; slot_mask = 4'b0001;
        run_frame();
        chk("R9", "oe held after last fall", int'(oe_fall[0][15]), 1);
        chk("R9", "oe dropped at next rise", int'(oe_mid[1][0]), 0);
        cfg_hiz_on_rise = 0; slot_mask = 4'b0011;
        run_frame();
        chk("R8", "oe kept, next slot active", int'(oe_fall[0][15]), 1);
        chk("R8", "oe dropped after slot1", int'(oe_fall[1][15]), 0);
    endtask

    task automatic t_mute();
        cfg_mute = 1; slot_mask = 4'b0001;
        load(13'h1FFF);
        rx_feed[0] = 16'h5A5A;
        run_frame();
        chk("R11", "muted word", int'(tx_seen[0]), 0);
        chk("R11", "oe while muted", int'(oe_mid[0][3]), 1);
        chk("R11", "rx while muted", rx_n == 1 ? int'(rx_log[0]) : -1,
            int'(exp_rx(16'h5A5A, 1, 0)));
        cfg_mute = 0;
    endtask

    task automatic t_repeat();
        logic [15:0] w;
        cfg_gain = 3'd2; slot_mask = 4'b0100;
        load(13'h0ABC);
        run_frame();
        run_frame();
        w = exp_word(13'h0ABC, 1, 0, 3'd2);
        chk("R12", "resent sample", int'(tx_seen[2]), int'(w));
        load(13'h1111);
        run_frame();
        chk("R12", "new sample after load", int'(tx_seen[2]),
            int'(exp_word(13'h1111, 1, 0, 3'd2)));
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; bclk_rise = 0; bclk_fall = 0; slot_idx = 0; bit_idx = 0;
        slot_mask = 0; cfg_sign_fill = 0; cfg_len13 = 1; cfg_lsb_first = 0;
        cfg_hiz_en = 1; cfg_hiz_on_rise = 0; cfg_mute = 0; cfg_gain = 0;
        tx_sample = 0; tx_load = 0; pcm_in = 0; rx_n = 0; out_moved = 0;
        for (int s = 0; s < 4; s++) rx_feed[s] = 16'h0;
        t_reset();
        t_pad13_msb();
        t_pad8_lsb();
        t_sign();
        t_release();
        t_mute();
        t_repeat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule